// File: doc/BRIEF.md
# Bitwise Lookup-Table Logic Unit

This unit computes each output bit as a chosen boolean function of the input bits at the same position. A small truth table supplies the function. An 8-bit table gives a three-input function and a 4-bit table gives a two-input function. The table can be a constant from the instruction, a nibble picked from the low byte of a register operand, or a 4-bit condition field. Any function of up to three inputs can therefore be expressed with one operation, and the function can be chosen at run time.

There are two operand widths. The word path works on `WORD_W`-bit operands; the third operand is the old destination value, so a three-input operation overwrites it. The field path works on three 4-bit condition fields and writes its result under a per-bit mask. Bits whose mask bit is clear keep the old field value. Results are registered. `valid_o` follows `valid_i` by one clock, and the outputs hold whenever `valid_i` is low.

Top module: `bitlut_unit`

## Requirements
- R1: The mode `MODE_WORD_TERN` (mode_i = 0) drives `word_o[i] = tbl_imm_i[idx]` with `idx = op_z_i[i]*4 + op_y_i[i]*2 + op_x_i[i]`. Bit 0 of the table is its LSB.
- R2: In mode 1, the two-input table is `tbl_byte_i[3:0]` when `nib_hi_i` = 0 and `tbl_byte_i[7:4]` when `nib_hi_i` = 1. Then `word_o[i] = table[op_y_i[i]*2 + op_x_i[i]]`.
- R3: In every two-input mode (1, 2, 4), the third operand (`op_z_i` or `fld_z_i`) has no effect on the result.
- R4: In mode 2, the two-input word table is `fld_tbl_i`, with the same index as in R2.
- R5: In mode 3 (field ternary), every bit i that has `mask_i[i]` = 1 gives `field_o[i] = tbl_imm_i[fld_z_i[i]*4 + fld_y_i[i]*2 + fld_x_i[i]]`.
- R6: In the field modes (3, 4), every bit that has `mask_i[i]` = 0 gives `field_o[i] = fld_old_i[i]`.
- R7: In mode 4 (field binary), every bit that has `mask_i[i]` = 1 gives `field_o[i] = fld_tbl_i[fld_y_i[i]*2 + fld_x_i[i]]`.
- R8: `valid_o` equals `valid_i` delayed by one clock. Results show in the cycle after the one in which `valid_i` is high. While `valid_i` is low, `word_o` and `field_o` hold their values.
- R9: In the field modes `word_o` is 0. In the word modes (0, 1, 2), `field_o` equals `fld_old_i`. For the unused mode codes 5 to 7, `word_o` is 0 and `field_o` equals `fld_old_i`.
- R10: After reset, `valid_o`, `word_o` and `field_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| mode_i | input | 3 | Operation mode, codes 0 to 4 |
| op_x_i | input | WORD_W | Word operand, index weight 1 |
| op_y_i | input | WORD_W | Word operand, index weight 2 |
| op_z_i | input | WORD_W | Old destination word, index weight 4 |
| tbl_imm_i | input | 8 | Three-input truth table |
| tbl_byte_i | input | 8 | Low byte of the table register |
| nib_hi_i | input | 1 | Selects the upper nibble of tbl_byte_i |
| fld_x_i | input | 4 | Field operand, index weight 1 |
| fld_y_i | input | 4 | Field operand, index weight 2 |
| fld_z_i | input | 4 | Field operand, index weight 4 |
| fld_tbl_i | input | 4 | Two-input truth table taken from a field |
| fld_old_i | input | 4 | Old destination field |
| mask_i | input | 4 | Per-bit write mask for the field |
| valid_o | output | 1 | Result valid |
| word_o | output | WORD_W | Word result |
| field_o | output | 4 | Field result |

## Verification
The bench builds the unit with the default `WORD_W` = 64 and a 4-bit field. This brings all 64 bit lanes within reach, and random operands place every table index in almost every lane. It applies the majority table 0xE8, the three-way XOR table 0x96 and random tables in every mode. The mask, nibble-select, ignored-operand and hold cases are checked at the outputs.

// File: rtl/bitlut_pkg.sv
package bitlut_pkg;
  localparam int TBL3_W = 8;
  localparam int TBL2_W = 4;
  localparam int FLD_W  = 4;

  typedef enum logic [2:0] {
    MODE_WORD_TERN    = 3'd0,
    MODE_WORD_BIN_REG = 3'd1,
    MODE_WORD_BIN_FLD = 3'd2,
    MODE_FLD_TERN     = 3'd3,
    MODE_FLD_BIN      = 3'd4
  } lut_mode_e;
endpackage

// File: rtl/bitlut_tbl_sel.sv
module bitlut_tbl_sel
  import bitlut_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [TBL3_W-1:0] tbl_imm_i,
  input  logic [TBL3_W-1:0] tbl_byte_i,
  input  logic              nib_hi_i,
  input  logic [TBL2_W-1:0] fld_tbl_i,
  output logic [TBL3_W-1:0] word_tbl_o,
  output logic [TBL3_W-1:0] fld_tbl_o,
  output logic              word_en_o,
  output logic              fld_en_o
);
  logic [TBL2_W-1:0] nib;
  assign nib = nib_hi_i ? tbl_byte_i[7:4] : tbl_byte_i[3:0];

  // A 4-entry table is doubled to 8 so the weight-4 input selects nothing
  always_comb begin
    word_tbl_o = '0;
    fld_tbl_o  = '0;
    word_en_o  = 1'b0;
    fld_en_o   = 1'b0;
    unique case (mode_i)
      MODE_WORD_TERN:    begin word_tbl_o = tbl_imm_i;            word_en_o = 1'b1; end
      MODE_WORD_BIN_REG: begin word_tbl_o = {nib, nib};           word_en_o = 1'b1; end
      MODE_WORD_BIN_FLD: begin word_tbl_o = {fld_tbl_i, fld_tbl_i}; word_en_o = 1'b1; end
      MODE_FLD_TERN:     begin fld_tbl_o  = tbl_imm_i;            fld_en_o  = 1'b1; end
      MODE_FLD_BIN:      begin fld_tbl_o  = {fld_tbl_i, fld_tbl_i}; fld_en_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitlut_array.sv
module bitlut_array
  import bitlut_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [TBL3_W-1:0] tbl_i,
  input  logic [N-1:0]      x_i,
  input  logic [N-1:0]      y_i,
  input  logic [N-1:0]      z_i,
  output logic [N-1:0]      res_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign res_o[g] = tbl_i[{z_i[g], y_i[g], x_i[g]}];
  end
endmodule

// File: rtl/bitlut_unit.sv
module bitlut_unit
  import bitlut_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] op_x_i,
  input  logic [WORD_W-1:0] op_y_i,
  input  logic [WORD_W-1:0] op_z_i,
  input  logic [7:0]        tbl_imm_i,
  input  logic [7:0]        tbl_byte_i,
  input  logic              nib_hi_i,
  input  logic [3:0]        fld_x_i,
  input  logic [3:0]        fld_y_i,
  input  logic [3:0]        fld_z_i,
  input  logic [3:0]        fld_tbl_i,
  input  logic [3:0]        fld_old_i,
  input  logic [3:0]        mask_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [3:0]        field_o
);
  logic [TBL3_W-1:0] word_tbl, fld_tbl;
  logic              word_en, fld_en;
  logic [WORD_W-1:0] word_lut;
  logic [FLD_W-1:0]  fld_lut;
  logic [WORD_W-1:0] word_nxt;
  logic [FLD_W-1:0]  fld_nxt;

  bitlut_tbl_sel i_tbl_sel (
    .mode_i     (mode_i),
    .tbl_imm_i  (tbl_imm_i),
    .tbl_byte_i (tbl_byte_i),
    .nib_hi_i   (nib_hi_i),
    .fld_tbl_i  (fld_tbl_i),
    .word_tbl_o (word_tbl),
    .fld_tbl_o  (fld_tbl),
    .word_en_o  (word_en),
    .fld_en_o   (fld_en)
  );

  bitlut_array #(.N(WORD_W)) i_word_arr (
    .tbl_i (word_tbl),
    .x_i   (op_x_i),
    .y_i   (op_y_i),
    .z_i   (op_z_i),
    .res_o (word_lut)
  );

  bitlut_array #(.N(FLD_W)) i_fld_arr (
    .tbl_i (fld_tbl),
    .x_i   (fld_x_i),
    .y_i   (fld_y_i),
    .z_i   (fld_z_i),
    .res_o (fld_lut)
  );

  assign word_nxt = word_en ? word_lut : '0;
  assign fld_nxt  = fld_en ? ((fld_lut & mask_i) | (fld_old_i & ~mask_i)) : fld_old_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      field_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        word_o  <= word_nxt;
        field_o <= fld_nxt;
      end
    end
  end

  assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(word_o) && $stable(field_o)));

  assert_mask_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (mode_i == MODE_FLD_TERN || mode_i == MODE_FLD_BIN)) |->
      ((field_o & ~$past(mask_i)) == ($past(fld_old_i) & ~$past(mask_i))));

  assert_field_word_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (mode_i == MODE_FLD_TERN || mode_i == MODE_FLD_BIN)) |-> (word_o == '0));

  assert_word_field_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (mode_i < 3'd3)) |-> (field_o == $past(fld_old_i)));
endmodule

// File: tb/test_bitlut_unit.sv
module test_bitlut_unit;
  localparam int W = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   mode_i = '0;
  logic [W-1:0] op_x_i = '0, op_y_i = '0, op_z_i = '0;
  logic [7:0]   tbl_imm_i = '0, tbl_byte_i = '0;
  logic         nib_hi_i = 1'b0;
  logic [3:0]   fld_x_i = '0, fld_y_i = '0, fld_z_i = '0, fld_tbl_i = '0, fld_old_i = '0, mask_i = '0;
  logic         valid_o;
  logic [W-1:0] word_o;
  logic [3:0]   field_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  bitlut_unit #(.WORD_W(W)) i_bitlut_unit (
    .clk_i, .rst_ni, .valid_i, .mode_i, .op_x_i, .op_y_i, .op_z_i,
    .tbl_imm_i, .tbl_byte_i, .nib_hi_i, .fld_x_i, .fld_y_i, .fld_z_i,
    .fld_tbl_i, .fld_old_i, .mask_i, .valid_o, .word_o, .field_o
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_word(input int m, input logic [W-1:0] x, y, z,
      input logic [7:0] imm, byt, input logic nh, input logic [3:0] ft);
    logic [W-1:0] r = '0;
    int t8;
    int t4;
    t4 = nh ? (byt >> 4) & 15 : byt & 15;
    for (int i = 0; i < W; i++) begin
      int k;
      if (m == 0) begin
        k = 4 * z[i] + 2 * y[i] + x[i];
        t8 = imm;
        r[i] = (t8 >> k) & 1;
      end else if (m == 1) begin
        k = 2 * y[i] + x[i];
        r[i] = (t4 >> k) & 1;
      end else if (m == 2) begin
        k = 2 * y[i] + x[i];
        r[i] = (ft >> k) & 1;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] model_fld(input int m, input logic [3:0] x, y, z,
      input logic [7:0] imm, input logic [3:0] ft, old, mk);
    logic [3:0] r;
    r = old;
    for (int i = 0; i < 4; i++) begin
      if (mk[i] && m == 3) r[i] = imm[4 * z[i] + 2 * y[i] + x[i]];
      if (mk[i] && m == 4) r[i] = ft[2 * y[i] + x[i]];
    end
    return r;
  endfunction

  // Issued at a falling edge; the result is registered at the next rising edge
  task automatic issue(input string req, input int m, input logic [W-1:0] x, y, z,
      input logic [7:0] imm, byt, input logic nh, input logic [3:0] fx, fy, fz, ft, fo, mk);
    logic [W-1:0] ew;
    logic [3:0]   ef;
    mode_i = 3'(m); op_x_i = x; op_y_i = y; op_z_i = z;
    tbl_imm_i = imm; tbl_byte_i = byt; nib_hi_i = nh;
    fld_x_i = fx; fld_y_i = fy; fld_z_i = fz; fld_tbl_i = ft; fld_old_i = fo; mask_i = mk;
    valid_i = 1'b1;
    ew = model_word(m, x, y, z, imm, byt, nh, ft);
    ef = model_fld(m, fx, fy, fz, imm, ft, fo, mk);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid R8"}, W'(valid_o), W'(1));
    chk({req, " word"}, word_o, ew);
    chk({req, " field"}, W'(field_o), W'(ef));
  endtask

  function automatic logic [W-1:0] rw();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y, z, hw;
    logic [3:0]   hf;
    repeat (3) @(negedge clk_i);
    chk("R10 valid", W'(valid_o), '0);
    chk("R10 word", word_o, '0);
    chk("R10 field", W'(field_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int n = 0; n < 20; n++) begin
      issue("R1 majority", 0, rw(), rw(), rw(), 8'hE8, 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
      issue("R1 xor3", 0, rw(), rw(), rw(), 8'h96, 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
      issue("R1 random", 0, rw(), rw(), rw(), 8'($urandom), 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
    end
    issue("R1 select z", 0, rw(), rw(), 64'hF0F0_1234_0000_FFFF, 8'hF0, 8'h00, 1'b0,
          4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);

    for (int n = 0; n < 10; n++) begin
      issue("R2 low nibble", 1, rw(), rw(), rw(), 8'($urandom), 8'h6A, 1'b0,
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
      issue("R2 high nibble", 1, rw(), rw(), rw(), 8'($urandom), 8'h6A, 1'b1,
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
      issue("R4 field table", 2, rw(), rw(), rw(), 8'($urandom), 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
    end

    for (int n = 0; n < 6; n++) begin
      x = rw(); y = rw(); z = rw();
      issue("R3 z ignored reg", 1, x, y, z, 8'h00, 8'h9C, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
      issue("R3 z ignored reg inv", 1, x, y, ~z, 8'h00, 8'h9C, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
      issue("R3 z ignored fld", 2, x, y, ~z, 8'h00, 8'h00, 1'b0, 4'h0, 4'h0, 4'h0, 4'h6, 4'h0, 4'h0);
      issue("R3 fld z ignored", 4, x, y, z, 8'h00, 8'h00, 1'b0, 4'h5, 4'h3, 4'($urandom), 4'h8, 4'h0, 4'hF);
    end

    for (int n = 0; n < 16; n++) begin
      issue("R5 field majority", 3, rw(), rw(), rw(), 8'hE8, 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'(n));
      issue("R6 field xor3 masked", 3, rw(), rw(), rw(), 8'h96, 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'(15 - n));
      issue("R7 field binary", 4, rw(), rw(), rw(), 8'($urandom), 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'(n));
    end
    issue("R6 mask zero", 3, rw(), rw(), rw(), 8'hFF, 8'h00, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'hA, 4'h0);

    for (int m = 5; m < 8; m++)
      issue("R9 unused mode", m, rw(), rw(), rw(), 8'hFF, 8'hFF, 1'b1,
            4'hF, 4'hF, 4'hF, 4'hF, 4'h9, 4'hF);

    issue("R8 setup", 0, rw(), rw(), rw(), 8'h96, 8'h00, 1'b0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6);
    hw = word_o; hf = field_o;
    for (int n = 0; n < 4; n++) begin
      mode_i = 3'(n); op_x_i = rw(); op_y_i = rw(); op_z_i = rw();
      tbl_imm_i = 8'($urandom); fld_old_i = 4'($urandom); mask_i = 4'hF;
      @(negedge clk_i);
      chk("R8 idle valid", W'(valid_o), '0);
      chk("R8 idle word hold", word_o, hw);
      chk("R8 idle field hold", W'(field_o), W'(hf));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule